// File: doc/BRIEF.md
# Peripheral Set/Clear Register Bank with Interrupt

This block is the register file that sits in front of one peripheral on a word-wide peripheral bus. It holds a mode word that software reads and writes, and a write-only command register whose one bits become single-cycle pulses toward the peripheral. It also holds a bank of channel-enable bits and an interrupt mask. Software never read-modify-writes the channel bits or the mask. It writes ones to a "turn on" address or a "turn off" address, and zero bits leave the stored value alone.

The peripheral reports events on a vector of event inputs. The low bits of that vector (chosen by a parameter) are sticky: a pulse sets the bit, and reading the event-status word clears it. The remaining bits are level bits that show the input as sampled one cycle earlier. The interrupt line is high whenever any event-status bit and its mask bit are both set.

Bus accesses are plain strobes with no handshake and complete in one cycle. Read data is combinational while a read is presented. Any clear-on-read effect happens at the clock edge that ends the read.

Top module: `periph_regbank`

Byte offsets (the low two address bits are ignored):
- 0x00: command, write-only
- 0x04: mode, read/write
- 0x08: channel on, write-only
- 0x0C: channel off, write-only
- 0x10: channel state, read-only
- 0x14: event status, read-only, sticky bits clear on read
- 0x18: interrupt on, write-only
- 0x1C: interrupt off, write-only
- 0x20: interrupt mask, read-only

## Requirements
- R1: After reset the mode word, channel state, interrupt mask and event status are all 0, and both cmd_pulse and irq_out are low.
- R2: A write to 0x00 drives cmd_pulse with wdata[CMD_BITS-1:0] for exactly the one cycle after the write edge; zero bits give no pulse, and cmd_pulse is 0 in every other cycle.
- R3: A write to 0x04 stores wdata[MODE_BITS-1:0] in the mode word, which is visible on mode_cfg and reads back at 0x04; writes to any other address leave it unchanged.
- R4: A write to 0x08 sets, and a write to 0x0C clears, each channel bit whose wdata bit is 1; zero bits leave the state unchanged, and the state reads back at 0x10 and on chan_on.
- R5: A write to 0x18 sets, and a write to 0x1C clears, each interrupt mask bit whose wdata bit is 1; the mask reads back at 0x20.
- R6: irq_out is high exactly when some bit is 1 in both the event status and the interrupt mask, with no added cycle of delay.
- R7: A sticky event bit (index below the STICKY_MASK ones, default bits 3:0) is set by a one-cycle pulse on evt_in and cleared by a read of 0x14; if the read and a new pulse arrive in the same cycle, the bit stays set.
- R8: Non-sticky event bits (default bits 7:4) show evt_in as registered on the previous edge, and a read does not clear them.
- R9: Reads of write-only addresses (0x00, 0x08, 0x0C, 0x18, 0x1C) and of unmapped addresses return 0, bus_rdata is 0 when no read is presented, and writes to read-only addresses change nothing.
- R10: Register bits above each register's width always read 0.
- R11: Address bits 1:0 are ignored, so every access acts on the whole word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational during a read |
| evt_in | input | STAT_BITS (8) | Event inputs from the peripheral |
| cmd_pulse | output | CMD_BITS (4) | One-cycle command pulses |
| mode_cfg | output | MODE_BITS (12) | Current mode word |
| chan_on | output | CHAN_BITS (6) | Current channel enable state |
| irq_out | output | 1 | Interrupt source line |

## Verification
The assertions assume one access at a time on the bus. A single address can never name the turn-on and turn-off registers together, so the priority of clear over set is only reachable from the internal set/clear vectors. They also assume that evt_in is held steady around the clock edge. The bench drives every input, including the event vector, on the falling edge and samples outputs just before the next falling edge. Sticky event pulses are exactly one cycle wide, except in the case that lines up a pulse with a status read on purpose.

// File: rtl/prb_pkg.sv
package prb_pkg;

  // Word index of each register (byte offset / 4).
  typedef enum logic [3:0] {
    IDX_CMD     = 4'd0,
    IDX_MODE    = 4'd1,
    IDX_CHON    = 4'd2,
    IDX_CHOFF   = 4'd3,
    IDX_CHSTAT  = 4'd4,
    IDX_EVSTAT  = 4'd5,
    IDX_IRQON   = 4'd6,
    IDX_IRQOFF  = 4'd7,
    IDX_IRQMASK = 4'd8
  } reg_idx_e;

  typedef struct packed {
    logic cmd;
    logic mode;
    logic chon;
    logic choff;
    logic irqon;
    logic irqoff;
  } wr_hit_t;

  typedef struct packed {
    logic mode;
    logic chstat;
    logic evstat;
    logic irqmask;
  } rd_hit_t;

endpackage

// File: rtl/prb_decode.sv
module prb_decode
  import prb_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             sel_i,
  input  logic             write_i,
  input  logic [IDX_W-1:0] idx_i,
  output wr_hit_t          wr_o,
  output rd_hit_t          rd_o
);

  logic do_wr;
  logic do_rd;

  assign do_wr = sel_i & write_i;
  assign do_rd = sel_i & ~write_i;

  always_comb begin
    wr_o        = '0;
    rd_o        = '0;
    wr_o.cmd    = do_wr && (idx_i == IDX_W'(IDX_CMD));
    wr_o.mode   = do_wr && (idx_i == IDX_W'(IDX_MODE));
    wr_o.chon   = do_wr && (idx_i == IDX_W'(IDX_CHON));
    wr_o.choff  = do_wr && (idx_i == IDX_W'(IDX_CHOFF));
    wr_o.irqon  = do_wr && (idx_i == IDX_W'(IDX_IRQON));
    wr_o.irqoff = do_wr && (idx_i == IDX_W'(IDX_IRQOFF));
    rd_o.mode    = do_rd && (idx_i == IDX_W'(IDX_MODE));
    rd_o.chstat  = do_rd && (idx_i == IDX_W'(IDX_CHSTAT));
    rd_o.evstat  = do_rd && (idx_i == IDX_W'(IDX_EVSTAT));
    rd_o.irqmask = do_rd && (idx_i == IDX_W'(IDX_IRQMASK));
  end

endmodule

// File: rtl/prb_setclr.sv
module prb_setclr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= (q_o | set_i) & ~clr_i;  // clear has priority
  end

  assert_set_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & ~clr_i) != '0) |=> ((q_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));

  assert_clr_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((q_o & $past(clr_i)) == '0));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i == '0) && (clr_i == '0)) |=> $stable(q_o));

endmodule

// File: rtl/prb_evstat.sv
module prb_evstat #(
  parameter int             W      = 8,
  parameter logic [W-1:0]   STICKY = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         rd_clr_i,
  output logic [W-1:0] q_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (STICKY[b]) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q_o[b] <= 1'b0;
        else if (evt_i[b]) q_o[b] <= 1'b1;   // new event beats the read clear
        else if (rd_clr_i) q_o[b] <= 1'b0;
      end
    end else begin : g_level
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o[b] <= 1'b0;
        else        q_o[b] <= evt_i[b];
      end
    end
  end

  assert_evt_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & STICKY) != '0) |=> ((q_o & $past(evt_i & STICKY)) == $past(evt_i & STICKY)));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && ((evt_i & STICKY) == '0)) |=> ((q_o & STICKY) == '0));

  assert_level_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_o & ~STICKY) == ($past(evt_i) & ~STICKY)));

endmodule

// File: rtl/periph_regbank.sv
module periph_regbank
  import prb_pkg::*;
#(
  parameter int                    DATA_W     = 32,
  parameter int                    ADDR_W     = 6,
  parameter int                    CMD_BITS   = 4,
  parameter int                    MODE_BITS  = 12,
  parameter int                    CHAN_BITS  = 6,
  parameter int                    STAT_BITS  = 8,
  parameter logic [STAT_BITS-1:0]  STICKY_MASK = 8'h0F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [STAT_BITS-1:0] evt_in,
  output logic [CMD_BITS-1:0]  cmd_pulse,
  output logic [MODE_BITS-1:0] mode_cfg,
  output logic [CHAN_BITS-1:0] chan_on,
  output logic                 irq_out
);

  localparam int IDX_W = ADDR_W - 2;

  wr_hit_t              wr_hit;
  rd_hit_t              rd_hit;
  logic [MODE_BITS-1:0] mode_q;
  logic [CMD_BITS-1:0]  cmd_q;
  logic [STAT_BITS-1:0] mask_q;
  logic [STAT_BITS-1:0] stat_q;
  logic                 unused_bits;

  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  prb_decode #(.IDX_W(IDX_W)) u_dec (
    .sel_i   (bus_sel),
    .write_i (bus_write),
    .idx_i   (bus_addr[ADDR_W-1:2]),
    .wr_o    (wr_hit),
    .rd_o    (rd_hit)
  );

  // Command register: a write turns into a single-cycle pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cmd_q <= '0;
    else if (wr_hit.cmd) cmd_q <= bus_wdata[CMD_BITS-1:0];
    else                 cmd_q <= '0;
  end
  assign cmd_pulse = cmd_q;

  // Mode register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mode_q <= '0;
    else if (wr_hit.mode) mode_q <= bus_wdata[MODE_BITS-1:0];
  end
  assign mode_cfg = mode_q;

  prb_setclr #(.W(CHAN_BITS)) u_chan (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i ({CHAN_BITS{wr_hit.chon}}  & bus_wdata[CHAN_BITS-1:0]),
    .clr_i ({CHAN_BITS{wr_hit.choff}} & bus_wdata[CHAN_BITS-1:0]),
    .q_o   (chan_on)
  );

  prb_setclr #(.W(STAT_BITS)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i ({STAT_BITS{wr_hit.irqon}}  & bus_wdata[STAT_BITS-1:0]),
    .clr_i ({STAT_BITS{wr_hit.irqoff}} & bus_wdata[STAT_BITS-1:0]),
    .q_o   (mask_q)
  );

  prb_evstat #(.W(STAT_BITS), .STICKY(STICKY_MASK)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_in),
    .rd_clr_i (rd_hit.evstat),
    .q_o      (stat_q)
  );

  assign irq_out = |(stat_q & mask_q);

  always_comb begin
    bus_rdata = '0;
    unique case (1'b1)
      rd_hit.mode:    bus_rdata = DATA_W'(mode_q);
      rd_hit.chstat:  bus_rdata = DATA_W'(chan_on);
      rd_hit.evstat:  bus_rdata = DATA_W'(stat_q);
      rd_hit.irqmask: bus_rdata = DATA_W'(mask_q);
      default:        bus_rdata = '0;
    endcase
  end

  assert_cmd_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit.cmd |=> (cmd_pulse == '0));

  assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit.mode |=> $stable(mode_cfg));

  assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((mask_q != '0) && (stat_q != '0)));

  assert_idle_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_write) |-> (bus_rdata == '0));

  assert_one_read_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_hit));

endmodule

// File: tb/sim_periph_regbank.sv
`timescale 1ns/1ps
module sim_periph_regbank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  evt_in = '0;
  logic [3:0]  cmd_pulse;
  logic [11:0] mode_cfg;
  logic [5:0]  chan_on;
  logic        irq_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  periph_regbank u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .cmd_pulse(cmd_pulse), .mode_cfg(mode_cfg),
    .chan_on(chan_on), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_write = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pulse_evt(input logic [7:0] v);
    @(negedge clk);
    evt_in = v;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 cmd_pulse", 32'(cmd_pulse), 0);
    check("R1 mode_cfg", 32'(mode_cfg), 0);
    check("R1 chan_on", 32'(chan_on), 0);
    check("R1 irq_out", 32'(irq_out), 0);
    rd(6'h20, d); check("R1 mask", d, 0);
    rd(6'h14, d); check("R1 status", d, 0);
    check("R9 idle rdata", bus_rdata, 0);
  endtask

  task automatic t_command();
    wr(6'h00, 32'hFFFF_FFF5);
    check("R2 pulse", 32'(cmd_pulse), 32'h5);
    @(negedge clk);
    check("R2 pulse gone", 32'(cmd_pulse), 0);
    wr(6'h00, 32'h0);
    check("R2 zero write", 32'(cmd_pulse), 0);
  endtask

  task automatic t_mode();
    logic [31:0] d;
    wr(6'h04, 32'hFFFF_FABC);
    check("R3 mode_cfg", 32'(mode_cfg), 32'hABC);
    rd(6'h04, d); check("R10 mode readback", d, 32'hABC);
    wr(6'h10, 32'h0);
    wr(6'h00, 32'h0);
    check("R3 mode kept", 32'(mode_cfg), 32'hABC);
  endtask

  task automatic t_channel();
    logic [31:0] d;
    wr(6'h08, 32'h05); check("R4 on", 32'(chan_on), 32'h05);
    wr(6'h08, 32'h12); check("R4 on merge", 32'(chan_on), 32'h17);
    wr(6'h0C, 32'h04); check("R4 off", 32'(chan_on), 32'h13);
    wr(6'h0C, 32'h00); check("R4 off zero", 32'(chan_on), 32'h13);
    rd(6'h10, d);      check("R4 readback", d, 32'h13);
    wr(6'h08, 32'hFFFF_FFFF);
    rd(6'h10, d);      check("R10 chan width", d, 32'h3F);
    wr(6'h10, 32'h0);  check("R9 ro write", 32'(chan_on), 32'h3F);
    wr(6'h0C, 32'h3F); check("R4 all off", 32'(chan_on), 0);
  endtask

  task automatic t_mask_irq();
    logic [31:0] d;
    pulse_evt(8'h01);
    check("R6 masked", 32'(irq_out), 0);
    wr(6'h18, 32'h01); check("R6 unmasked", 32'(irq_out), 1);
    wr(6'h1C, 32'h01); check("R6 remasked", 32'(irq_out), 0);
    rd(6'h20, d);      check("R5 mask off", d, 0);
    wr(6'h18, 32'h03);
    rd(6'h20, d);      check("R5 mask on", d, 32'h03);
    check("R6 irq", 32'(irq_out), 1);
    rd(6'h14, d);      check("R7 status", d, 32'h01);
    check("R6 cleared", 32'(irq_out), 0);
    wr(6'h18, 32'hFFFF);
    rd(6'h20, d);      check("R10 mask width", d, 32'hFF);
    wr(6'h20, 32'h0);
    rd(6'h20, d);      check("R9 ro mask", d, 32'hFF);
    wr(6'h1C, 32'hFF);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse_evt(8'h04);
    rd(6'h14, d); check("R7 set", d, 32'h04);
    rd(6'h14, d); check("R7 clear", d, 0);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = 6'h14; evt_in = 8'h02;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; evt_in = '0;
    check("R7 read old", d, 0);
    rd(6'h14, d); check("R7 collision kept", d, 32'h02);
    rd(6'h14, d); check("R7 then cleared", d, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk); evt_in = 8'h30;
    rd(6'h14, d); check("R8 level", d, 32'h30);
    rd(6'h14, d); check("R8 not cleared", d, 32'h30);
    @(negedge clk); evt_in = '0;
    @(negedge clk);
    rd(6'h14, d); check("R8 dropped", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(6'h04, 32'h555);
    wr(6'h08, 32'h2A);
    rd(6'h00, d); check("R9 cmd read", d, 0);
    rd(6'h08, d); check("R9 on read", d, 0);
    rd(6'h0C, d); check("R9 off read", d, 0);
    rd(6'h18, d); check("R9 ien read", d, 0);
    rd(6'h1C, d); check("R9 idis read", d, 0);
    rd(6'h24, d); check("R9 unmapped", d, 0);
    rd(6'h3C, d); check("R9 top", d, 0);
    wr(6'h14, 32'hFF);
    rd(6'h14, d); check("R9 ro status", d, 0);
    wr(6'h28, 32'hFFFF_FFFF);
    check("R9 unmapped write mode", 32'(mode_cfg), 32'h555);
    check("R9 unmapped write chan", 32'(chan_on), 32'h2A);
  endtask

  task automatic t_addr_low();
    logic [31:0] d;
    wr(6'h07, 32'h123);
    check("R11 write offset", 32'(mode_cfg), 32'h123);
    rd(6'h05, d); check("R11 read offset", d, 32'h123);
    wr(6'h0A, 32'h01);
    check("R11 chan offset", 32'(chan_on), 32'h2B);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_command();
    t_mode();
    t_channel();
    t_mask_irq();
    t_sticky();
    t_level();
    t_unmapped();
    t_addr_low();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule